// File: doc/BRIEF.md
# Staircase Sensor Light Controller

This block switches three staircase lamps, one for each motion sensor. The sensors are placed from the lowest landing to the highest. Each lamp channel first cleans its raw sensor level, so that short bounces are dropped. It then runs a small state machine that keeps the lamp lit for a minimum time after a short visit. If the sensor stayed active for longer than that minimum, the lamp stays lit while the sensor is active and goes out after a shorter tail once the sensor goes quiet.

The clock input is the timing tick, 10 Hz in normal use. With the default counts, the minimum hold is 8 s, the tail is 4 s and the glitch limit is 0.5 s. A static energy-saving input couples the channels. When one lamp starts, every other lamp whose filtered sensor is quiet is switched off at the same clock edge. This mode assumes a single person on the stairs. When the input is low, the three channels are fully independent.

Each channel has four states. **IDLE**: lamp off. **SENSE**: lamp lit, sensor active. **HOLD**: lamp lit, sensor quiet, the minimum time has not yet run out. **TAIL**: lamp lit, sensor quiet, the post-activity tail is running. The transitions are:
- *start*: IDLE→SENSE when the filtered sensor is active.
- *short_release*: SENSE→HOLD when the sensor drops before the minimum is reached.
- *long_release*: SENSE→TAIL when the sensor drops after the minimum.
- *retrigger*: HOLD or TAIL→SENSE when the sensor returns.
- *hold_done*: HOLD→IDLE.
- *tail_done*: TAIL→IDLE.
- *handoff*: SENSE, HOLD or TAIL→IDLE when energy saving forces the lamp off.

Top module: `stair_light_ctrl`

## Requirements
- R1: While rst_n is low, every lamp output is 0 and every channel returns to IDLE with its counters cleared. The first cycle after reset shows all lamps off.
- R2: A lamp turns on at the clock edge that follows the edge at which its filtered sensor becomes 1. The lamp never turns on while its filtered sensor is 0.
- R3: A raw sensor level is accepted only after it has been sampled unchanged on FILT_TICKS consecutive edges. A pulse shorter than that changes no lamp and no timer.
- R4: If the filtered sensor was active for fewer than HOLD_TICKS cycles, the lamp stays lit for exactly HOLD_TICKS cycles counted from turn-on (short_release, then hold_done).
- R5: If the filtered sensor was active for HOLD_TICKS cycles or more, the lamp stays lit while the sensor is active. It then stays lit for exactly TAIL_TICKS more cycles, so the total lit time is the active length plus TAIL_TICKS (long_release, then tail_done).
- R6: If the filtered sensor returns during HOLD or TAIL, the channel goes back to SENSE and its timing restarts from that edge (retrigger).
- R7: With eco_en=1, when a channel takes its start transition, every other lit channel whose filtered sensor is 0 goes to IDLE at the same edge (handoff).
- R8: With eco_en=0, a start on one channel has no effect on the lamps of the others.
- R9: With eco_en=1, a lit channel whose filtered sensor is 1 is never switched off by the handoff of another channel.
- R10: A quiet gap on the raw sensor that is shorter than FILT_TICKS does not end an active period. The lit time is that of a single press spanning the gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing tick clock (10 Hz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| eco_en | input | 1 | Static energy-saving select, 1 = handoff enabled |
| sense | input | N_LAMP | Raw motion sensor levels, bit 0 = lowest landing |
| lamp | output | N_LAMP | Lamp enables, bit i lit while channel i is not IDLE |

## Verification
The bench builds the block with FILT_TICKS=3, HOLD_TICKS=12 and TAIL_TICKS=6. With these values, every state and transition is reached within a few dozen cycles, and the thousands of random cycles cover many full short, long and retriggered visits. The short counts also put the boundaries next to each other: a pulse one tick below the filter limit, a press that ends just before the minimum, and a handoff that lands inside another channel's hold or tail. All of these fit in short directed scenarios, and the bench measures each one with exact lit-cycle totals.

// File: rtl/stair_pkg.sv
package stair_pkg;
    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_SENSE = 2'd1,
        CH_HOLD  = 2'd2,
        CH_TAIL  = 2'd3
    } ch_state_e;
endpackage

// File: rtl/stair_deglitch.sv
module stair_deglitch #(
    parameter int FILT_TICKS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_TICKS - 1);

    logic [CW-1:0] run_q;

    // A level is taken once it has been seen on FILT_TICKS edges in a row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean <= 1'b0;
            run_q <= '0;
        end else if (raw == clean) begin
            run_q <= '0;
        end else if (run_q == LAST) begin
            clean <= raw;
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/stair_channel.sv
module stair_channel
    import stair_pkg::*;
#(
    parameter int HOLD_TICKS = 80,
    parameter int TAIL_TICKS = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    input  logic kill,
    output logic start,
    output logic lit
);
    localparam int MAXT = (HOLD_TICKS > TAIL_TICKS) ? HOLD_TICKS : TAIL_TICKS;
    localparam int CW   = $clog2(MAXT + 1);
    localparam logic [CW-1:0] HOLD_END = CW'(HOLD_TICKS);
    localparam logic [CW-1:0] TAIL_END = CW'(TAIL_TICKS);
    localparam logic [CW-1:0] ONE      = CW'(1);

    ch_state_e     st_q, st_d;
    logic [CW-1:0] tm_q, tm_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= CH_IDLE;
            tm_q <= '0;
        end else begin
            st_q <= st_d;
            tm_q <= tm_d;
        end
    end

    always_comb begin
        st_d = st_q;
        tm_d = tm_q;
        unique case (st_q)
            CH_IDLE: begin
                if (act) begin
                    st_d = CH_SENSE;
                    tm_d = ONE;
                end
            end
            CH_SENSE: begin
                if (act) begin
                    tm_d = (tm_q == HOLD_END) ? tm_q : tm_q + 1'b1;
                end else if (kill) begin
                    st_d = CH_IDLE;
                    tm_d = '0;
                end else if (tm_q == HOLD_END) begin
                    st_d = CH_TAIL;
                    tm_d = ONE;
                end else begin
                    st_d = CH_HOLD;
                    tm_d = tm_q + 1'b1;
                end
            end
            CH_HOLD: begin
                if (act) begin
                    st_d = CH_SENSE;
                    tm_d = ONE;
                end else if (kill || tm_q == HOLD_END) begin
                    st_d = CH_IDLE;
                    tm_d = '0;
                end else begin
                    tm_d = tm_q + 1'b1;
                end
            end
            CH_TAIL: begin
                if (act) begin
                    st_d = CH_SENSE;
                    tm_d = ONE;
                end else if (kill || tm_q == TAIL_END) begin
                    st_d = CH_IDLE;
                    tm_d = '0;
                end else begin
                    tm_d = tm_q + 1'b1;
                end
            end
            default: begin
                st_d = CH_IDLE;
                tm_d = '0;
            end
        endcase
    end

    always_comb begin
        lit   = (st_q != CH_IDLE);
        start = (st_q == CH_IDLE) && act;
    end
endmodule

// File: rtl/stair_light_ctrl.sv
module stair_light_ctrl #(
    parameter int N_LAMP     = 3,
    parameter int FILT_TICKS = 5,
    parameter int HOLD_TICKS = 80,
    parameter int TAIL_TICKS = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eco_en,
    input  logic [N_LAMP-1:0] sense,
    output logic [N_LAMP-1:0] lamp
);
    localparam logic [N_LAMP-1:0] BIT0 = N_LAMP'(1);

    logic [N_LAMP-1:0] filt_vec;
    logic [N_LAMP-1:0] start_vec;
    logic [N_LAMP-1:0] kill_vec;

    for (genvar g = 0; g < N_LAMP; g++) begin : g_ch
        stair_deglitch #(
            .FILT_TICKS(FILT_TICKS)
        ) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (sense[g]),
            .clean(filt_vec[g])
        );

        assign kill_vec[g] = eco_en && (|(start_vec & ~(BIT0 << g)));

        stair_channel #(
            .HOLD_TICKS(HOLD_TICKS),
            .TAIL_TICKS(TAIL_TICKS)
        ) u_ch (
            .clk  (clk),
            .rst_n(rst_n),
            .act  (filt_vec[g]),
            .kill (kill_vec[g]),
            .start(start_vec[g]),
            .lit  (lamp[g])
        );
    end
endmodule

// File: rtl/stair_light_chk.sv
module stair_light_chk #(
    parameter int N_LAMP = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              eco_en,
    input logic [N_LAMP-1:0] sense,
    input logic [N_LAMP-1:0] filt,
    input logic [N_LAMP-1:0] lamp
);
    // R1
    reset_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> lamp == '0);

    for (genvar i = 0; i < N_LAMP; i++) begin : g_one
        // R2
        lit_needs_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!lamp[i] && !filt[i]) |=> !lamp[i]);

        // R3
        filter_follows_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (filt[i] != $past(filt[i])) |-> ($past(sense[i]) == filt[i]));

        // R5
        stay_lit_while_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lamp[i] && filt[i]) |=> lamp[i]);

        for (genvar j = 0; j < N_LAMP; j++) begin : g_pair
            if (i != j) begin : g_diff
                // R7
                handoff_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (eco_en && $rose(lamp[i]) && $past(lamp[j]) && !$past(filt[j]))
                    |-> !lamp[j]);
            end
        end
    end
endmodule

bind stair_light_ctrl stair_light_chk #(
    .N_LAMP(N_LAMP)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .eco_en(eco_en),
    .sense (sense),
    .filt  (filt_vec),
    .lamp  (lamp)
);

// File: tb/sim_stair_light_ctrl.sv
`timescale 1ns/1ps
module sim_stair_light_ctrl;
    localparam int N = 3;
    localparam int F = 3;
    localparam int H = 12;
    localparam int T = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         eco_en = 1'b0;
    logic [N-1:0] sense = '0;
    logic [N-1:0] lamp;

    int n_chk = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;
    bit clr = 1'b0;
    int on_cnt [N];

    // reference state: 0 idle, 1 sense, 2 hold, 3 tail
    int m_f [N];
    int m_run [N];
    int m_st [N];
    int m_tm [N];

    always #4 clk = ~clk;

    stair_light_ctrl #(
        .N_LAMP(N), .FILT_TICKS(F), .HOLD_TICKS(H), .TAIL_TICKS(T)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .eco_en(eco_en), .sense(sense), .lamp(lamp)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    function automatic int model_lamps();
        int v = 0;
        for (int i = 0; i < N; i++) if (m_st[i] != 0) v |= (1 << i);
        return v;
    endfunction

    // cycle reference built from the requirements
    always @(posedge clk) begin
        int st0 [N];
        int f0 [N];
        int strt [N];
        int any;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_f[i] = 0; m_run[i] = 0; m_st[i] = 0; m_tm[i] = 0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                st0[i] = m_st[i]; f0[i] = m_f[i];
                strt[i] = (st0[i] == 0 && f0[i] == 1) ? 1 : 0;
            end
            for (int i = 0; i < N; i++) begin
                any = 0;
                for (int j = 0; j < N; j++) if (j != i && strt[j] == 1) any = 1;
                any = any & int'(eco_en);
                case (st0[i])
                    0: if (f0[i] == 1) begin m_st[i] = 1; m_tm[i] = 1; end
                    1: if (f0[i] == 1) begin if (m_tm[i] < H) m_tm[i]++; end
                       else if (any == 1) begin m_st[i] = 0; m_tm[i] = 0; end
                       else if (m_tm[i] >= H) begin m_st[i] = 3; m_tm[i] = 1; end
                       else begin m_st[i] = 2; m_tm[i]++; end
                    default: begin
                        if (f0[i] == 1) begin m_st[i] = 1; m_tm[i] = 1; end
                        else if (any == 1) begin m_st[i] = 0; m_tm[i] = 0; end
                        else if (m_tm[i] >= ((st0[i] == 2) ? H : T)) begin m_st[i] = 0; m_tm[i] = 0; end
                        else m_tm[i]++;
                    end
                endcase
                if (int'(sense[i]) == m_f[i]) m_run[i] = 0;
                else if (m_run[i] == F - 1) begin m_f[i] = int'(sense[i]); m_run[i] = 0; end
                else m_run[i]++;
            end
        end
        for (int i = 0; i < N; i++) begin
            if (clr) on_cnt[i] = 0;
            else if (lamp[i]) on_cnt[i]++;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) check(int'(lamp) == model_lamps(), "R2 R4 R5 R6 R7 cycle", int'(lamp), model_lamps());
    end

    task automatic idle_for(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press(input int ch, input int len);
        sense[ch] = 1'b1;
        idle_for(len);
        sense[ch] = 1'b0;
    endtask

    task automatic clear_counts();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int rem [N];
        void'($urandom(32'd20240611));
        idle_for(4);
        check(lamp == '0, "R1 reset", int'(lamp), 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        idle_for(2);
        check(lamp == '0, "R1 after reset", int'(lamp), 0);

        // R3: pulse one tick short of the filter
        clear_counts(); press(0, F - 1); idle_for(30);
        check(on_cnt[0] == 0, "R3 glitch", on_cnt[0], 0);
        // R4: short visit
        clear_counts(); press(0, F + 2); idle_for(40);
        check(on_cnt[0] == H, "R4 short hold", on_cnt[0], H);
        // R5: long visit
        clear_counts(); press(1, H + 10); idle_for(40);
        check(on_cnt[1] == H + 10 + T, "R5 long tail", on_cnt[1], H + 10 + T);
        // R6: retrigger inside the hold
        clear_counts(); press(2, F + 1); idle_for(F + 1); press(2, F + 1); idle_for(40);
        check(on_cnt[2] == 2 * F + 2 + H, "R6 retrigger", on_cnt[2], 2 * F + 2 + H);
        // R10: short dip in a long press
        clear_counts(); press(0, H + 4); idle_for(F - 1); press(0, 5); idle_for(40);
        check(on_cnt[0] == H + 8 + F + T, "R10 dip", on_cnt[0], H + 8 + F + T);
        // R8: independent channels
        clear_counts(); press(0, F + 1); press(1, F + 1); idle_for(40);
        check(on_cnt[0] == H, "R8 ch0 kept", on_cnt[0], H);
        check(on_cnt[1] == H, "R8 ch1", on_cnt[1], H);
        // R7: handoff cuts the earlier lamp
        eco_en = 1'b1;
        clear_counts(); press(0, F + 1); press(1, F + 1); idle_for(40);
        check(on_cnt[0] == F + 1, "R7 ch0 cut", on_cnt[0], F + 1);
        check(on_cnt[1] == H, "R7 ch1", on_cnt[1], H);
        // R9: active channel survives handoff
        clear_counts();
        sense[0] = 1'b1; idle_for(F + 3); press(1, F + 1); idle_for(5); sense[0] = 1'b0;
        idle_for(40);
        check(on_cnt[0] == 2 * F + 9 + T, "R9 ch0 kept", on_cnt[0], 2 * F + 9 + T);
        check(on_cnt[1] == H, "R9 ch1", on_cnt[1], H);

        // random traffic, both modes
        for (int i = 0; i < N; i++) rem[i] = 0;
        for (int blk = 0; blk < 10; blk++) begin
            eco_en = blk[0];
            for (int c = 0; c < 500; c++) begin
                for (int i = 0; i < N; i++) begin
                    if (rem[i] == 0) begin
                        sense[i] = 1'($urandom_range(0, 1));
                        rem[i] = $urandom_range(1, 2 * H);
                    end else rem[i]--;
                end
                @(negedge clk);
            end
        end
        sense = '0;
        idle_for(40);
        check(lamp == '0, "R4 R5 all dark", int'(lamp), 0);
        cmp_on = 1'b0;
        finish_run();
    end
endmodule